// File: doc/BRIEF.md
# Timer Control, Interrupt Latch and Status

This block sits beside a three-counter interval timer and supplies everything around the counters. It has a control register that enables interrupts and chains the counters together for longer intervals, and a status register that reports the live counter outputs together with the interrupt latch. It also has a clear port that releases a pending interrupt. Software reaches these through a byte-wide register interface with four local offsets. The counters and the bus address decode are outside this block.

The interrupt latch captures a rising edge on counter 0's output while interrupts are enabled, and it stays set until software writes to the clear offset. An external chassis interrupt input is passed through to the request line while interrupts are enabled. The block also divides the bus oscillator, which is its clock, by a fixed ratio to make the timer's input clock.

Top module: `timer_ctl_status`

## Requirements
- R1: A write at offset 0 loads the control register from data bits 2..0 on the next clock edge. Data bits 7..3 have no effect on any output.
- R2: While reset is held and right after it, the control register, the interrupt latch and the divider are all zero. So `irq_req`, `carry_link` and `tmr_clk` are all 0.
- R3: Control bit 0 drives `carry_link[0]`, which links counter 1 to counter 0. Control bit 1 drives `carry_link[1]`, which links counter 2 to counter 1. Control bit 2 is the interrupt enable.
- R4: A rising edge on `cnt_out[0]`, seen at a clock edge while the interrupt enable is 1, sets the latch at that edge. `irq_req` is then high.
- R5: A rising edge while the enable is 0 does not set the latch. Neither does a `cnt_out[0]` level that stays high across a change of the enable to 1.
- R6: A write of any data value at offset 2 clears the latch on the next edge. If a qualifying rising edge arrives in the same cycle, the latch stays set.
- R7: Once set, the latch holds until it is cleared, whatever the counter outputs do.
- R8: A read at offset 1 returns the latch in bit 7, zeros in bits 6..3 and `cnt_out[2:0]` in bits 2..0, combinationally. Every other offset reads as 0.
- R9: `irq_req` is the latch ORed with `ext_irq` gated by the interrupt enable. `ext_irq` never sets the latch.
- R10: `tmr_clk` has a period of 14 clocks. After reset it is low for 7 clocks and then high for 7.
- R11: A write at offset 3 (interrupt-level set) changes neither the control register nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Local register offset (0 control, 1 status, 2 clear, 3 level) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected offset |
| cnt_out | input | 3 | Output levels of counters 2..0 |
| ext_irq | input | 1 | External chassis interrupt |
| irq_req | output | 1 | Interrupt request |
| carry_link | output | 2 | Counter chaining enables |
| tmr_clk | output | 1 | Divided timer input clock |

## Verification
A wrong latch state shows at `irq_req` and at status bit 7 in the cycle after the edge or clear that caused it. The reference model therefore catches a missed or spurious set within one clock. A corrupted control register shows at once on `carry_link`, or on `irq_req` when `ext_irq` is held high. A divider that slips shows as a `tmr_clk` transition in the wrong cycle, at the latest within one period of 14 clocks.

// File: rtl/tmr_ctl_pkg.sv
// Package: shared offsets and layout constants for the timer control block.
// Assumes a two-bit local offset inside the block's four-byte window.
package tmr_ctl_pkg;
    localparam int OFS_W = 2;
    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL   = 2'd0,
        OFS_STATUS = 2'd1,
        OFS_CLEAR  = 2'd2,
        OFS_LEVEL  = 2'd3
    } tmr_ofs_e;
endpackage

// File: rtl/tmr_clk_div.sv
// Module: divides the bus clock by DIV_RATIO into a near-square timer clock.
// Assumes DIV_RATIO >= 2; output is low for the first half after reset.
module tmr_clk_div #(
    parameter int DIV_RATIO = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic tmr_clk
);
    localparam int CW   = $clog2(DIV_RATIO);
    localparam int HALF = DIV_RATIO / 2;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] HI_START = CW'(DIV_RATIO - HALF);

    logic [CW-1:0] phase_q;

    // Phase counter wraps after DIV_RATIO clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign tmr_clk = (phase_q >= HI_START);

    // Checker state: cycles since the previous rising edge of tmr_clk.
    logic          prev_tclk_q;
    logic          seen_rise_q;
    logic [CW-1:0] gap_q;
    logic          rise_now;
    assign rise_now = tmr_clk && !prev_tclk_q;

    // Tracks spacing between rising edges for the period check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tclk_q <= 1'b0;
            seen_rise_q <= 1'b0;
            gap_q       <= '0;
        end else begin
            prev_tclk_q <= tmr_clk;
            if (rise_now) begin
                seen_rise_q <= 1'b1;
                gap_q       <= '0;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    a_r10_period: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && seen_rise_q) |-> (gap_q == LAST));
endmodule

// File: rtl/tmr_ctrl_reg.sv
// Module: control register holding carry links and the interrupt enable.
// Assumes the caller qualifies the write strobe with the control offset.
module tmr_ctrl_reg #(
    parameter int NUM_CNT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_stb,
    input  logic [NUM_CNT-1:0] ld_data,
    output logic [NUM_CNT-2:0] links,
    output logic               irq_en
);
    localparam int IE_BIT = NUM_CNT - 1;

    logic [NUM_CNT-1:0] ctrl_q;

    // Loads the control bits on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (ld_stb) ctrl_q <= ld_data;
    end

    assign links  = ctrl_q[IE_BIT-1:0];
    assign irq_en = ctrl_q[IE_BIT];

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> (ctrl_q == $past(ld_data)));
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stb |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr_irq_latch.sv
// Module: captures a rising edge of counter 0's output while enabled.
// Assumes cnt0 is synchronous to clk; a same-cycle edge beats a clear.
module tmr_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic cnt0,
    input  logic clr_stb,
    output logic pending
);
    logic cnt0_prev_q;
    logic edge_set;

    assign edge_set = irq_en && cnt0 && !cnt0_prev_q;

    // Remembers the previous counter 0 level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt0_prev_q <= 1'b0;
        else        cnt0_prev_q <= cnt0;
    end

    // Sets on a qualified edge, clears on a write to the clear port.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (edge_set) pending <= 1'b1;
        else if (clr_stb)  pending <= 1'b0;
    end

    a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && cnt0 && !$past(cnt0)) |=> pending);
    a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(irq_en));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !(irq_en && cnt0 && !cnt0_prev_q)) |=> !pending);
    a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr_stb) |=> pending);
endmodule

// File: rtl/timer_ctl_status.sv
// Module: top of the timer control block; decodes the four local offsets,
// builds the status byte and drives the interrupt request.
// Assumes address decode above this block selects the four-byte window.
module timer_ctl_status
    import tmr_ctl_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_CNT   = 3,
    parameter int DIV_RATIO = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OFS_W-1:0]   reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_CNT-1:0] cnt_out,
    input  logic               ext_irq,
    output logic               irq_req,
    output logic [NUM_CNT-2:0] carry_link,
    output logic               tmr_clk
);
    localparam int PAD_W = DATA_W - 1 - NUM_CNT;

    logic ctrl_stb, clr_stb, irq_en, pending;
    logic wdata_unused;

    assign ctrl_stb     = reg_wr && (reg_addr == OFS_CTRL);
    assign clr_stb      = reg_wr && (reg_addr == OFS_CLEAR);
    assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_CNT];

    tmr_ctrl_reg #(.NUM_CNT(NUM_CNT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_stb  (ctrl_stb),
        .ld_data (reg_wdata[NUM_CNT-1:0]),
        .links   (carry_link),
        .irq_en  (irq_en)
    );

    tmr_irq_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_en  (irq_en),
        .cnt0    (cnt_out[0]),
        .clr_stb (clr_stb),
        .pending (pending)
    );

    tmr_clk_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_clk (tmr_clk)
    );

    // Request combines the latch with the gated chassis interrupt.
    assign irq_req = pending || (irq_en && ext_irq);

    // Read mux: only the status offset returns data.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STATUS)
            reg_rdata = {pending, {PAD_W{1'b0}}, cnt_out};
    end

    a_r9_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !pending) |-> (irq_en && ext_irq));
    a_r11_level_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_LEVEL && !pending) |=> ($stable(carry_link) && $stable(irq_en)));
    a_r8_status_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-2:NUM_CNT] == '0));
endmodule

// File: tb/timer_ctl_status_tb.sv
// Bench: behavioural reference model stepped each clock and compared.
module timer_ctl_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [2:0] cnt_out = 3'd0;
    logic       ext_irq = 1'b0;
    logic       irq_req;
    logic [1:0] carry_link;
    logic       tmr_clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    bit [2:0] m_ctrl;
    bit       m_latch;
    bit       m_prev;
    int       m_div;

    always #5 clk = ~clk;

    timer_ctl_status u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_out(cnt_out),
        .ext_irq(ext_irq), .irq_req(irq_req), .carry_link(carry_link),
        .tmr_clk(tmr_clk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit set;
        if (!rst_n) begin
            m_ctrl = 0; m_latch = 0; m_prev = 0; m_div = 0;
        end else begin
            set = m_ctrl[2] && cnt_out[0] && !m_prev;
            if (set) m_latch = 1;
            else if (reg_wr && reg_addr == 2'd2) m_latch = 0;
            if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[2:0];
            m_prev = cnt_out[0];
            m_div = (m_div == 13) ? 0 : m_div + 1;
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        exp_rd = (reg_addr == 2'd1) ? {m_latch, 4'b0, cnt_out} : 0;
        chk("R4 irq_req", irq_req, m_latch | (m_ctrl[2] & ext_irq));
        chk("R3 carry_link", carry_link, m_ctrl[1:0]);
        chk("R10 tmr_clk", tmr_clk, (m_div >= 7) ? 1 : 0);
        chk("R8 reg_rdata", reg_rdata, exp_rd);
    endtask

    // One clock: model follows the edge, outputs compared 1 ns later.
    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2: reset state.
        repeat (3) step();
        chk("R2 irq_req in reset", irq_req, 0);
        chk("R2 carry_link in reset", carry_link, 0);
        rst_n = 1'b1;
        step();
        chk("R2 tmr_clk after reset", tmr_clk, 0);

        // R1/R3: upper data bits ignored, links set, enable off.
        wr(2'd0, 8'hFB);
        chk("R1 links from low bits", carry_link, 2'b11);
        ext_irq = 1'b1; step();
        chk("R1 bit7..3 no enable", irq_req, 0);
        ext_irq = 1'b0;

        // R5: rise while disabled, then level held high across enable.
        cnt_out[0] = 1'b1; step(); step();
        chk("R5 disabled rise", irq_req, 0);
        wr(2'd0, 8'h04);
        step(); step();
        chk("R5 held level", irq_req, 0);
        chk("R3 links cleared", carry_link, 2'b00);

        // R4: fresh rising edge sets the latch.
        cnt_out[0] = 1'b0; step();
        cnt_out[0] = 1'b1; step();
        chk("R4 edge sets", irq_req, 1);
        reg_addr = 2'd1; step();
        chk("R8 status latch", reg_rdata, 8'h81);

        // R7: latch holds through counter activity.
        cnt_out = 3'b110; step(); cnt_out = 3'b011; step(); cnt_out = 3'b000; step();
        chk("R7 holds", irq_req, 1);

        // R11: level-set write is inert.
        wr(2'd3, 8'hFF);
        chk("R11 latch kept", irq_req, 1);
        chk("R11 links kept", carry_link, 0);

        // R6: clear with any value.
        wr(2'd2, 8'h00);
        chk("R6 cleared", irq_req, 0);

        // R6: edge in same cycle as clear keeps latch set.
        cnt_out[0] = 1'b1;
        wr(2'd2, 8'h5A);
        chk("R6 edge beats clear", irq_req, 1);
        cnt_out[0] = 1'b0;
        wr(2'd2, 8'hA5);
        chk("R6 second clear", irq_req, 0);

        // R9: external interrupt gated by enable, never latched.
        ext_irq = 1'b1; step();
        chk("R9 ext passes", irq_req, 1);
        ext_irq = 1'b0; step();
        chk("R9 ext not latched", irq_req, 0);
        wr(2'd0, 8'h02);
        ext_irq = 1'b1; step();
        chk("R9 ext blocked", irq_req, 0);
        chk("R3 link2 only", carry_link, 2'b10);
        ext_irq = 1'b0;

        // R8: read every offset with varied counter patterns.
        for (int i = 0; i < 16; i++) begin
            reg_addr = 2'(i);
            cnt_out  = 3'(i * 5);
            step();
        end

        // R10: run long enough to cover several divider periods.
        repeat (40) step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule